// File: doc/BRIEF.md
# Serial Flash Status and Write-Guard Unit

This unit holds the status byte of a serial NOR flash and decides, one command at a time, whether a modifying command may proceed. The command decoder upstream gives it single-cycle pulses for each decoded command, together with the target byte address, the data byte of a status write, the level of the write-protect pin and a pulse that marks the end of an internal program, erase or status-write cycle. The unit answers every command pulse with exactly one accept or reject pulse on the following clock. It also keeps the busy flag, the write-enable latch, the protected-region field, the status-protect bit, the secure-mode flag and the one-time lock.

The protected region is a 3-bit field that selects the top eighth, quarter or half of the array, all of it, or none of it. A status-protect bit, together with a low write-protect pin, freezes the non-volatile status fields. In secure mode, status bit 7 shows a one-time lock instead of the status-protect bit. In that mode a status write only sets the lock. Program and erase are then confined to the top sector until the lock is set, and are refused after that.

Serial shifting, array storage and cycle timing are handled by neighbouring blocks. The non-volatile fields are plain registers here.

Top module: `sflash_guard`

## Requirements
- R1: After reset the status byte is 0x00, the secure-mode flag and the lock are 0, and neither accept nor reject is asserted.
- R2: Status byte layout: bit 0 busy, bit 1 write-enable latch, bits 4:2 protect field, bits 6:5 always 0, bit 7 status-protect bit in normal mode and the one-time lock in secure mode.
- R3: Write-enable sets the latch and write-disable clears it. A cycle-done pulse while busy clears both the busy bit and the latch. A cycle-done pulse while idle changes nothing.
- R4: A status write, program, sector erase, block erase or chip erase is rejected when the latch is 0 or the busy bit is 1. A rejected command leaves the status unchanged.
- R5: Every command pulse yields exactly one accept or reject pulse on the next clock, and no pulse follows an idle cycle. An accepted status write, program or erase sets the busy bit on that same clock. Write-enable, write-disable and secure entry are always accepted.
- R6: Protect field 000 protects nothing. 001 protects 0x70000-0x7FFFF, 010 protects 0x60000-0x7FFFF, 011 protects 0x40000-0x7FFFF, and any value with bit 2 set protects the whole array.
- R7: Program, sector erase and block erase aimed at a protected address are rejected. Chip erase is accepted only when the protect field is 000.
- R8: When the status-protect bit is 1 and the write-protect pin is low (the hardware lock output is 1), a status write in normal mode is rejected and bits 7:2 keep their values.
- R9: An accepted status write in normal mode loads bit 7 and bits 4:2 from the data byte. Data bits 6, 5, 1 and 0 have no effect on the status.
- R10: In secure mode an accepted status write ignores its data, leaves the protect field and status-protect bit unchanged and sets the lock to 1. The lock is never cleared except by reset.
- R11: Secure-entry sets secure mode and write-disable leaves it. In secure mode, a program, sector erase or block erase is accepted only if the lock is 0, the address is in the top 4 KiB sector (0x7F000-0x7FFFF) and that address is unprotected. Chip erase is always rejected in secure mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wren_i | input | 1 | Write-enable command pulse |
| wrdi_i | input | 1 | Write-disable / leave secure mode pulse |
| wrsr_i | input | 1 | Status write command pulse |
| prog_i | input | 1 | Page program command pulse |
| serase_i | input | 1 | Sector erase command pulse |
| berase_i | input | 1 | Block erase command pulse |
| cerase_i | input | 1 | Chip erase command pulse |
| secure_i | input | 1 | Enter secure mode command pulse |
| addr_i | input | ADDR_W | Target byte address of program or erase |
| wr_data_i | input | 8 | Data byte of a status write |
| wp_n_i | input | 1 | Write-protect pin level, active low |
| done_i | input | 1 | End-of-cycle pulse from the timing logic |
| status_o | output | 8 | Status byte |
| accept_o | output | 1 | Command accepted, one clock after the pulse |
| reject_o | output | 1 | Command rejected, one clock after the pulse |
| secure_o | output | 1 | Secure mode active |
| lock_o | output | 1 | One-time lock state |
| hw_lock_o | output | 1 | Status fields frozen by protect bit and pin |

## Verification
Directed sequences walk the region decode through each protect field value, with addresses placed one byte either side of every region edge. This separates a correct boundary from an off-by-one compare. Status writes carry data with the ignored bits set, so a write that leaks into bits 6, 5, 1 or 0 is caught. The same write is tried with the pin low and then high, which shows whether the pin qualifies the lock. The secure-mode sequence aims program and erase just inside and just outside the top sector, both before and after the lock is set, and then leaves and re-enters the mode to show that the lock persists. A long stretch of seeded random commands with random pin levels, end-of-cycle pulses and addresses drawn from edge values mixes commands with a busy cycle, with a cleared latch and with every lock state.

// File: rtl/sflash_guard_pkg.sv
package sflash_guard_pkg;

  localparam int STAT_W  = 8;
  localparam int FIELD_W = 3;

  // Command codes; order matches the pulse vector index plus one
  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_WREN   = 4'd1,
    OP_WRDI   = 4'd2,
    OP_WRSR   = 4'd3,
    OP_PROG   = 4'd4,
    OP_SERASE = 4'd5,
    OP_BERASE = 4'd6,
    OP_CERASE = 4'd7,
    OP_SECURE = 4'd8
  } op_e;

  typedef struct packed {
    logic               wip;
    logic               wel;
    logic [FIELD_W-1:0] bp;
    logic               srp;
    logic               lock;
    logic               secure;
  } guard_state_t;

  function automatic logic op_modifies(op_e op);
    return (op == OP_WRSR) || (op == OP_PROG) || (op == OP_SERASE) ||
           (op == OP_BERASE) || (op == OP_CERASE);
  endfunction

endpackage

// File: rtl/sflash_op_encode.sv
module sflash_op_encode
  import sflash_guard_pkg::*;
#(
  parameter int N_CMD = 8
) (
  input  logic [N_CMD-1:0] pulse_i,
  output op_e              op_o
);

  // Lowest index wins if more than one pulse arrives
  always_comb begin
    op_o = OP_NONE;
    for (int i = N_CMD - 1; i >= 0; i--) begin
      if (pulse_i[i]) op_o = op_e'(4'(i + 1));
    end
  end

endmodule

// File: rtl/sflash_region_dec.sv
module sflash_region_dec #(
  parameter int ADDR_W       = 19,
  parameter int SECTOR_BYTES = 4096
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        bp_i,
  output logic              prot_o,
  output logic              top_sect_o
);

  localparam int SECT_W = $clog2(SECTOR_BYTES);

  // Upper fractions: 1/8, 1/4, 1/2 of the array, or all of it
  always_comb begin
    case (bp_i)
      3'b000:  prot_o = 1'b0;
      3'b001:  prot_o = &addr_i[ADDR_W-1 -: 3];
      3'b010:  prot_o = &addr_i[ADDR_W-1 -: 2];
      3'b011:  prot_o = addr_i[ADDR_W-1];
      default: prot_o = 1'b1;
    endcase
  end

  assign top_sect_o = &addr_i[ADDR_W-1:SECT_W];

endmodule

// File: rtl/sflash_gate.sv
module sflash_gate
  import sflash_guard_pkg::*;
(
  input  op_e          op_i,
  input  guard_state_t st_i,
  input  logic         prot_i,
  input  logic         top_i,
  input  logic         wp_n_i,
  output logic         grant_o,
  output logic         mod_o
);

  logic ready;
  logic pin_lock;
  logic array_ok;

  always_comb begin
    ready    = st_i.wel & ~st_i.wip;
    pin_lock = st_i.srp & ~wp_n_i;
    array_ok = st_i.secure ? (~st_i.lock & top_i & ~prot_i) : ~prot_i;
    case (op_i)
      OP_WREN, OP_WRDI, OP_SECURE: grant_o = 1'b1;
      OP_WRSR:   grant_o = ready & (st_i.secure | ~pin_lock);
      OP_PROG, OP_SERASE, OP_BERASE: grant_o = ready & array_ok;
      OP_CERASE: grant_o = ready & ~st_i.secure & (st_i.bp == '0);
      default:   grant_o = 1'b0;
    endcase
    mod_o = op_modifies(op_i);
  end

endmodule

// File: rtl/sflash_state_regs.sv
module sflash_state_regs
  import sflash_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  op_e          op_i,
  input  logic         grant_i,
  input  logic         mod_i,
  input  logic         done_i,
  input  logic [7:0]   data_i,
  output guard_state_t st_o,
  output logic         acc_o,
  output logic         rej_o
);

  guard_state_t st_q, st_n;
  logic acc_n, rej_n;
  logic cyc_end, wrsr_ok, start;
  logic wip_en, wel_en, nv_en, lock_en, sec_en;
  logic unused_data;

  assign unused_data = ^{data_i[6:5], data_i[1:0]};

  always_comb begin
    cyc_end = done_i & st_q.wip;
    wrsr_ok = (op_i == OP_WRSR) & grant_i;
    start   = mod_i & grant_i;
    st_n    = st_q;

    if (cyc_end) st_n.wip = 1'b0;
    if (start)   st_n.wip = 1'b1;

    if (cyc_end)           st_n.wel = 1'b0;
    if (op_i == OP_WREN)   st_n.wel = 1'b1;
    if (op_i == OP_WRDI)   st_n.wel = 1'b0;

    if (wrsr_ok & ~st_q.secure) begin
      st_n.bp  = data_i[4:2];
      st_n.srp = data_i[7];
    end
    if (wrsr_ok & st_q.secure) st_n.lock = 1'b1;

    if (op_i == OP_SECURE) st_n.secure = 1'b1;
    if (op_i == OP_WRDI)   st_n.secure = 1'b0;

    wip_en  = cyc_end | start;
    wel_en  = cyc_end | (op_i == OP_WREN) | (op_i == OP_WRDI);
    nv_en   = wrsr_ok & ~st_q.secure;
    lock_en = wrsr_ok & st_q.secure;
    sec_en  = (op_i == OP_SECURE) | (op_i == OP_WRDI);

    acc_n = (op_i != OP_NONE) & grant_i;
    rej_n = (op_i != OP_NONE) & ~grant_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      acc_o <= 1'b0;
      rej_o <= 1'b0;
    end else begin
      if (wip_en)  st_q.wip    <= st_n.wip;
      if (wel_en)  st_q.wel    <= st_n.wel;
      if (nv_en) begin
        st_q.bp  <= st_n.bp;
        st_q.srp <= st_n.srp;
      end
      if (lock_en) st_q.lock   <= st_n.lock;
      if (sec_en)  st_q.secure <= st_n.secure;
      acc_o <= acc_n;
      rej_o <= rej_n;
    end
  end

  assign st_o = st_q;

  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.lock |=> st_q.lock);

  // R5
  acc_rej_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_o && rej_o));

endmodule

// File: rtl/sflash_guard.sv
module sflash_guard
  import sflash_guard_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int SECTOR_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic              prog_i,
  input  logic              serase_i,
  input  logic              berase_i,
  input  logic              cerase_i,
  input  logic              secure_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              wp_n_i,
  input  logic              done_i,
  output logic [7:0]        status_o,
  output logic              accept_o,
  output logic              reject_o,
  output logic              secure_o,
  output logic              lock_o,
  output logic              hw_lock_o
);

  localparam int N_CMD = 8;

  logic             rst_meta, rst_q;
  logic [N_CMD-1:0] cmd_vec;
  op_e              op;
  guard_state_t     st;
  logic             prot, top_sect, grant, is_mod;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  assign cmd_vec = {secure_i, cerase_i, berase_i, serase_i,
                    prog_i, wrsr_i, wrdi_i, wren_i};

  sflash_op_encode #(.N_CMD(N_CMD)) u_enc (
    .pulse_i (cmd_vec),
    .op_o    (op)
  );

  sflash_region_dec #(.ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES)) u_region (
    .addr_i     (addr_i),
    .bp_i       (st.bp),
    .prot_o     (prot),
    .top_sect_o (top_sect)
  );

  sflash_gate u_gate (
    .op_i    (op),
    .st_i    (st),
    .prot_i  (prot),
    .top_i   (top_sect),
    .wp_n_i  (wp_n_i),
    .grant_o (grant),
    .mod_o   (is_mod)
  );

  sflash_state_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_q),
    .op_i    (op),
    .grant_i (grant),
    .mod_i   (is_mod),
    .done_i  (done_i),
    .data_i  (wr_data_i),
    .st_o    (st),
    .acc_o   (accept_o),
    .rej_o   (reject_o)
  );

  assign status_o  = {(st.secure ? st.lock : st.srp), 2'b00, st.bp, st.wel, st.wip};
  assign secure_o  = st.secure;
  assign lock_o    = st.lock;
  assign hw_lock_o = st.srp & ~wp_n_i;

  logic any_cmd, mod_cmd, single;
  assign any_cmd = |cmd_vec;
  assign mod_cmd = |cmd_vec[6:2];
  assign single  = $onehot0(cmd_vec);

  // R5
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_q)
    single);

  // R4
  nowel_reject_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (single && mod_cmd && !status_o[1]) |=> reject_o);

  // R5
  answer_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (single && any_cmd) |=> (accept_o != reject_o));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !any_cmd |=> !(accept_o || reject_o));

  // R7
  ce_region_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (single && cerase_i && status_o[4:2] != 3'b000) |=> reject_o);

  // R8
  pin_lock_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (single && wrsr_i && !secure_o && status_o[7] && !wp_n_i)
      |=> (reject_o && $stable(status_o[7:2])));

  // R3
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (done_i && status_o[0] && !any_cmd) |=> (status_o[1:0] == 2'b00));

endmodule

// File: tb/sflash_guard_test.sv
module sflash_guard_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;

  localparam int C_NONE = 0, C_WREN = 1, C_WRDI = 2, C_WRSR = 3, C_PROG = 4,
                 C_SE = 5, C_BE = 6, C_CE = 7, C_SEC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wren = 0, wrdi = 0, wrsr = 0, prog = 0, serase = 0, berase = 0,
        cerase = 0, secure_c = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wp_n = 1'b1, done = 1'b0;
  logic [7:0] status;
  logic accept, reject, secure, lock, hw_lock;

  int checks = 0;
  int fails  = 0;

  bit m_wip, m_wel, m_srp, m_lock, m_sec;
  bit [2:0] m_bp;

  always #(CLK_PERIOD/2) clk = ~clk;

  sflash_guard #(.ADDR_W(AW), .SECTOR_BYTES(4096)) uut (
    .clk(clk), .rst_n(rst_n),
    .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr), .prog_i(prog),
    .serase_i(serase), .berase_i(berase), .cerase_i(cerase), .secure_i(secure_c),
    .addr_i(addr), .wr_data_i(wdata), .wp_n_i(wp_n), .done_i(done),
    .status_o(status), .accept_o(accept), .reject_o(reject),
    .secure_o(secure), .lock_o(lock), .hw_lock_o(hw_lock)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit m_prot(logic [AW-1:0] a, bit [2:0] bp);
    case (bp)
      3'd0:    return 1'b0;
      3'd1:    return a >= 19'h70000;
      3'd2:    return a >= 19'h60000;
      3'd3:    return a >= 19'h40000;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] m_status();
    return {(m_sec ? m_lock : m_srp), 2'b00, m_bp, m_wel, m_wip};
  endfunction

  function automatic bit m_grant(int op, logic [AW-1:0] a, logic wp);
    bit ready;
    ready = m_wel && !m_wip;
    case (op)
      C_WREN, C_WRDI, C_SEC: return 1'b1;
      C_WRSR: return ready && (m_sec || !(m_srp && !wp));
      C_PROG, C_SE, C_BE:
        if (m_sec) return ready && !m_lock && (a >= 19'h7F000) && !m_prot(a, m_bp);
        else       return ready && !m_prot(a, m_bp);
      C_CE: return ready && !m_sec && (m_bp == 3'd0);
      default: return 1'b0;
    endcase
  endfunction

  task automatic m_update(int op, logic [7:0] d, logic dn, bit g);
    if (dn && m_wip) begin
      m_wip = 0;
      m_wel = 0;
    end
    case (op)
      C_WREN: m_wel = 1;
      C_WRDI: begin m_wel = 0; m_sec = 0; end
      C_SEC:  m_sec = 1;
      C_WRSR: if (g) begin
        if (m_sec) m_lock = 1;
        else begin m_srp = d[7]; m_bp = d[4:2]; end
        m_wip = 1;
      end
      C_PROG, C_SE, C_BE, C_CE: if (g) m_wip = 1;
      default: ;
    endcase
  endtask

  task automatic step(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                      input logic wp, input logic dn, input string req);
    bit g;
    logic ea, er;
    @(negedge clk);
    wren = (op == C_WREN); wrdi = (op == C_WRDI); wrsr = (op == C_WRSR);
    prog = (op == C_PROG); serase = (op == C_SE); berase = (op == C_BE);
    cerase = (op == C_CE); secure_c = (op == C_SEC);
    addr = a; wdata = d; wp_n = wp; done = dn;
    g  = m_grant(op, a, wp);
    ea = (op != C_NONE) && g;
    er = (op != C_NONE) && !g;
    m_update(op, d, dn, g);
    @(negedge clk);
    wren = 0; wrdi = 0; wrsr = 0; prog = 0; serase = 0; berase = 0;
    cerase = 0; secure_c = 0; done = 0;
    chk(req, "status", status, m_status());
    chk(req, "acc/rej", {6'd0, accept, reject}, {6'd0, ea, er});
    chk(req, "secure", {7'd0, secure}, {7'd0, m_sec});
    chk(req, "lock", {7'd0, lock}, {7'd0, m_lock});
    chk(req, "hw_lock", {7'd0, hw_lock}, {7'd0, m_srp && !wp});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_wip = 0; m_wel = 0; m_srp = 0; m_lock = 0; m_sec = 0; m_bp = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "status", status, 8'h00);
    chk("R1", "secure/lock", {6'd0, secure, lock}, 8'h00);
    chk("R1", "acc/rej", {6'd0, accept, reject}, 8'h00);
  endtask

  function automatic logic [AW-1:0] pick_addr();
    case ($urandom % 10)
      0: return 19'h00000;
      1: return 19'h3FFFF;
      2: return 19'h40000;
      3: return 19'h5FFFF;
      4: return 19'h60000;
      5: return 19'h6FFFF;
      6: return 19'h70000;
      7: return 19'h7F000;
      8: return 19'h7EFFF;
      default: return AW'($urandom);
    endcase
  endfunction

  function automatic string req_of(int op);
    case (op)
      C_WREN, C_WRDI, C_NONE: return "R3";
      C_WRSR: return "R9";
      C_PROG, C_SE, C_BE, C_CE: return "R7";
      default: return "R11";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // latch and status write field positions
    step(C_WRSR, '0, 8'hFF, 1, 0, "R4");
    step(C_WREN, '0, 8'h00, 1, 0, "R3");
    step(C_WRSR, '0, 8'hE7, 1, 0, "R9");
    chk("R2", "layout", status, 8'h87);
    step(C_WREN, '0, 8'h00, 1, 0, "R5");
    step(C_PROG, '0, 8'h00, 1, 0, "R4");
    step(C_NONE, '0, 8'h00, 1, 1, "R3");
    chk("R3", "after done", status, 8'h84);
    step(C_NONE, '0, 8'h00, 1, 1, "R3");

    // protect field 001 edges
    step(C_WREN, '0, 8'h00, 1, 0, "R3");
    step(C_PROG, 19'h6FFFF, 8'h00, 1, 0, "R6");
    step(C_NONE, '0, 8'h00, 1, 1, "R3");
    step(C_WREN, '0, 8'h00, 1, 0, "R3");
    step(C_PROG, 19'h70000, 8'h00, 1, 0, "R6");
    step(C_BE, 19'h7FFFF, 8'h00, 1, 0, "R7");
    step(C_CE, '0, 8'h00, 1, 0, "R7");
    step(C_SE, 19'h10000, 8'h00, 1, 0, "R7");
    step(C_NONE, '0, 8'h00, 1, 1, "R3");

    // pin-qualified lock
    step(C_WREN, '0, 8'h00, 0, 0, "R3");
    step(C_WRSR, '0, 8'h0C, 0, 0, "R8");
    chk("R8", "frozen", status, 8'h86);
    step(C_WRSR, '0, 8'h0C, 1, 0, "R8");
    step(C_NONE, '0, 8'h00, 1, 1, "R3");

    // field 011 and 010 edges, then whole array
    step(C_WREN, '0, 8'h00, 1, 0, "R3");
    step(C_PROG, 19'h3FFFF, 8'h00, 1, 0, "R6");
    step(C_NONE, '0, 8'h00, 1, 1, "R3");
    step(C_WREN, '0, 8'h00, 1, 0, "R3");
    step(C_PROG, 19'h40000, 8'h00, 1, 0, "R6");
    step(C_WRSR, '0, 8'h08, 1, 0, "R6");
    step(C_NONE, '0, 8'h00, 1, 1, "R3");
    step(C_WREN, '0, 8'h00, 1, 0, "R3");
    step(C_SE, 19'h60000, 8'h00, 1, 0, "R6");
    step(C_SE, 19'h5FFFF, 8'h00, 1, 0, "R6");
    step(C_NONE, '0, 8'h00, 1, 1, "R3");
    step(C_WREN, '0, 8'h00, 1, 0, "R3");
    step(C_WRSR, '0, 8'h10, 1, 0, "R6");
    step(C_NONE, '0, 8'h00, 1, 1, "R3");
    step(C_WREN, '0, 8'h00, 1, 0, "R3");
    step(C_PROG, 19'h00000, 8'h00, 1, 0, "R6");
    step(C_WRSR, '0, 8'h00, 1, 0, "R9");
    step(C_NONE, '0, 8'h00, 1, 1, "R3");

    // secure mode
    step(C_SEC, '0, 8'h00, 1, 0, "R11");
    step(C_WREN, '0, 8'h00, 1, 0, "R3");
    step(C_PROG, 19'h7F000, 8'h00, 1, 0, "R11");
    step(C_NONE, '0, 8'h00, 1, 1, "R3");
    step(C_WREN, '0, 8'h00, 1, 0, "R3");
    step(C_PROG, 19'h7EFFF, 8'h00, 1, 0, "R11");
    step(C_CE, '0, 8'h00, 1, 0, "R11");
    step(C_WRSR, '0, 8'h1C, 1, 0, "R10");
    chk("R10", "lock bit", status, 8'h83);
    step(C_NONE, '0, 8'h00, 1, 1, "R3");
    step(C_WREN, '0, 8'h00, 1, 0, "R3");
    step(C_PROG, 19'h7FFFF, 8'h00, 1, 0, "R11");
    step(C_WRDI, '0, 8'h00, 1, 0, "R11");
    chk("R11", "left secure", status, 8'h00);
    step(C_SEC, '0, 8'h00, 1, 0, "R10");
    chk("R10", "lock kept", status, 8'h80);
    step(C_WRDI, '0, 8'h00, 1, 0, "R11");

    do_reset();

    for (int i = 0; i < 700; i++) begin
      int op;
      op = int'($urandom % 9);
      step(op, pick_addr(), 8'($urandom), ($urandom % 4) != 0,
           ($urandom % 3) == 0, req_of(op));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule